// File: doc/BRIEF.md
# Synchronous Output Clock Stop Controller

This block gates a bank of differential output clock pairs, each a true and a complement line, from one active-low stop request. The request crosses into the reference domain through a synchroniser that samples only on rising edges of the internal complement clock. The stop is then applied only where the true clock has just gone high. A stopped pair parks with its true line high and its complement line low, and it later resumes on the same kind of boundary, so no pulse is ever cut short.

A configuration register holds one stoppable bit per output. The register is copied into an active mask when a stop begins. Outputs whose bit is clear keep running through the stop. A separate per-output disable input drives both lines of its pair low, and it overrides the stop. Each output clock is modelled as register-derived logic that runs at half the reference clock rate.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset every pair runs, with its true line low and its complement line high in the first reference cycle. The configuration mask resets to all zeros, so a stop request has no effect until the mask is written.
- R2: The stop request `stop_ni` is active low. It passes through two samples taken on edges where the internal complement clock rises. A request that falls between those samples is seen at a later edge and is not lost.
- R3: Once the stop request is held low, every stoppable pair is parked within 2 to 6 output periods, which is 4 to 12 reference cycles.
- R4: A parked pair holds its true line at 1 and its complement line at 0. The true and complement lines of a pair are never both 1.
- R5: A pair whose mask bit is 0 keeps toggling while a stop is active.
- R6: Every change of a running true line lands on the common output phase. Stop and resume happen only at true-rising boundaries, so every low phase lasts exactly one reference cycle.
- R7: After `stop_ni` returns high, a stopped complement line is toggling high again within 6 reference cycles, which is 3 output periods.
- R8: When `out_dis_i[i]` = 1, pair i drives both lines to 0 from the next reference edge, whether or not a stop is active.
- R9: A pulse on `cfg_we_i` loads `cfg_mask_i` into the mask register. The mask is captured into the active mask only when a stop begins, so writes made while stopped take effect at the next stop.

Latencies and periods are given in reference cycles. One output period is two reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_ni | input | 1 | Stop request, active low, asynchronous |
| cfg_we_i | input | 1 | Write strobe for the stoppable mask |
| cfg_mask_i | input | N_OUT | New stoppable mask, bit i = 1 makes output i stoppable |
| out_dis_i | input | N_OUT | Per-output disable, 1 drives the pair low |
| clk_t_o | output | N_OUT | True output clocks |
| clk_c_o | output | N_OUT | Complement output clocks |

## Verification
The case that is hardest to reach from the ports is the mask snapshot. A mask write that lands while a stop is active must not change which pairs are parked, and it must show up at the following stop. To reach it, the stimulus writes the mask, holds a stop, rewrites the mask during that stop, releases, and then stops again. Short request pulses of varying length and phase offset drive the synchroniser to both of its possible sampling outcomes. A behavioural model follows each of these steps on every reference cycle.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef struct packed {
    logic t;
    logic c;
  } diff_pair_t;

  localparam int unsigned CNT_W = 4;
endpackage

// File: rtl/clkstop_phase.sv
module clkstop_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o,
  output logic cmp_rise_o,
  output logic true_rise_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign phase_o     = phase_q;
  // edge at which the complement output goes high
  assign cmp_rise_o  = phase_q;
  // edge at which the true output goes high
  assign true_rise_o = ~phase_q;
endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       phase_i,
  input  logic       park_i,
  input  logic       dis_i,
  output logic       dis_o,
  output diff_pair_t pair_o
);
  logic dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dis_q <= 1'b0;
    else         dis_q <= dis_i;
  end

  // park_i only changes on edges where phase_i goes high
  always_comb begin
    pair_o.t = ~dis_q & (phase_i | park_i);
    pair_o.c = ~dis_q & ~phase_i & ~park_i;
  end

  assign dis_o = dis_q;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned N_OUT       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_ni,
  input  logic             cfg_we_i,
  input  logic [N_OUT-1:0] cfg_mask_i,
  input  logic [N_OUT-1:0] out_dis_i,
  output logic [N_OUT-1:0] clk_t_o,
  output logic [N_OUT-1:0] clk_c_o
);
  logic             phase_q, cmp_rise, true_rise, stop_req;
  logic             stop_act_q;
  logic [N_OUT-1:0] cfg_q, amask_q, dis_q;

  clkstop_phase u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_o     (phase_q),
    .cmp_rise_o  (cmp_rise),
    .true_rise_o (true_rise)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cmp_rise),
    .d_i    (~stop_ni),
    .q_o    (stop_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_mask_i;
  end

  // stop state and mask snapshot move only at true-rising boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_act_q <= 1'b0;
      amask_q    <= '0;
    end else if (true_rise) begin
      stop_act_q <= stop_req;
      if (stop_req && !stop_act_q) amask_q <= cfg_q;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    diff_pair_t pr;
    clkstop_gate u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .phase_i (phase_q),
      .park_i  (stop_act_q & amask_q[g]),
      .dis_i   (out_dis_i[g]),
      .dis_o   (dis_q[g]),
      .pair_o  (pr)
    );
    assign clk_t_o[g] = pr.t;
    assign clk_c_o[g] = pr.c;
  end
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk
  import clkstop_pkg::*;
#(
  parameter int unsigned N_OUT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_ni,
  input logic [N_OUT-1:0] out_dis_i,
  input logic [N_OUT-1:0] clk_t_i,
  input logic [N_OUT-1:0] clk_c_i,
  input logic             phase_i,
  input logic [N_OUT-1:0] dis_q_i,
  input logic [N_OUT-1:0] amask_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic             past_ok;
  logic [CNT_W-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      lo_cnt  <= '0;
      hi_cnt  <= '0;
    end else begin
      past_ok <= 1'b1;
      lo_cnt  <= stop_ni ? '0 : (lo_cnt == CNT_MAX ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt  <= !stop_ni ? '0 : (hi_cnt == CNT_MAX ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  assert_never_both_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_t_i & clk_c_i) == '0);

  assert_dis_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (($past(out_dis_i) & (clk_t_i | clk_c_i)) == '0));

  assert_edge_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (((clk_t_i ^ $past(clk_t_i)) & ~dis_q_i & ~$past(dis_q_i)
                  & (clk_t_i ^ {N_OUT{phase_i}})) == '0));

  assert_park_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_cnt >= 4'd6) |-> ((amask_i & ~dis_q_i & ~(clk_t_i & ~clk_c_i)) == '0));

  assert_resume_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cnt >= 4'd6) |-> ((((clk_t_i ^ {N_OUT{phase_i}}) | (clk_c_i ^ ~{N_OUT{phase_i}}))
                           & ~dis_q_i) == '0));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stop_ni   (stop_ni),
  .out_dis_i (out_dis_i),
  .clk_t_i   (clk_t_o),
  .clk_c_i   (clk_c_o),
  .phase_i   (phase_q),
  .dis_q_i   (dis_q),
  .amask_i   (amask_q)
);

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0, stop_n = 1'b1, cfg_we = 1'b0;
  logic [N-1:0] cfg_mask = '0, dis = '0, t_o, c_o;
  int tests = 0, fails = 0, cyc = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  clkstop_ctrl #(.N_OUT(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .cfg_we_i(cfg_we),
    .cfg_mask_i(cfg_mask), .out_dis_i(dis), .clk_t_o(t_o), .clk_c_o(c_o));

  // behavioural reference
  bit m_ph, m_s1, m_s2, m_act;
  bit [N-1:0] m_cfg, m_snap, m_dis, e_t, e_c;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_s1 = 0; m_s2 = 0; m_act = 0; m_cfg = '0; m_snap = '0; m_dis = '0;
    end else begin
      if (m_ph) begin m_s2 = m_s1; m_s1 = !stop_n; end
      else begin
        if (m_s2 && !m_act) m_snap = m_cfg;
        m_act = m_s2;
      end
      if (cfg_we) m_cfg = cfg_mask;
      m_dis = dis;
      m_ph = !m_ph;
    end
  end

  always_comb
    for (int i = 0; i < N; i++) begin
      e_t[i] = !m_dis[i] && (m_ph || (m_act && m_snap[i]));
      e_c[i] = !m_dis[i] && !m_ph && !(m_act && m_snap[i]);
    end

  task automatic check(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    check(tag, {t_o, c_o}, {e_t, e_c});
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_mask(logic [N-1:0] m);
    cfg_mask = m; cfg_we = 1'b1; step(1); cfg_we = 1'b0;
  endtask

  int lat;
  logic [N-1:0] c_prev;
  bit [31:0] lfsr = 32'h1d2c_3b4a;

  initial begin
    step(3);
    check("R1", {t_o, c_o}, {{N{1'b0}}, {N{1'b1}}});
    rst_n = 1'b1;
    // R1: mask zero, stop has no effect
    stop_n = 1'b0; step(20);
    c_prev = c_o; step(1);
    check("R1", {28'd0, c_o ^ c_prev}, {28'd0, {N{1'b1}}});
    stop_n = 1'b1; step(10);

    // R2 R3 R4 R5: stop with mask 0101 at two phase offsets
    write_mask(4'b0101);
    for (int off = 0; off < 2; off++) begin
      tag = "R3"; step(off + 8);
      stop_n = 1'b0; lat = 0;
      while (!(t_o[0] && !t_o[1]) && lat < 40) begin step(1); lat++; end
      tests++;
      if (lat < 4 || lat > 12) begin
        fails++; $display("FAIL R3 latency actual=%0d expected=4..12", lat);
      end
      step(8);
      tag = "R4";
      check("R4", {28'd0, t_o[2], c_o[2], t_o[0], c_o[0]}, {28'd0, 4'b1010});
      c_prev = c_o; step(1);
      tag = "R5";
      check("R5", {30'd0, c_o[3] ^ c_prev[3], c_o[1] ^ c_prev[1]}, {30'd0, 2'b11});
      // R9: rewrite mask while stopped, no change yet
      tag = "R9"; write_mask(4'b1111); step(6);
      c_prev = c_o; step(1);
      check("R9", {31'd0, c_o[1] ^ c_prev[1]}, {31'd0, 1'b1});
      tag = "R7"; stop_n = 1'b1; lat = 0;
      while (!c_o[0] && lat < 40) begin step(1); lat++; end
      tests++;
      if (lat > 6) begin
        fails++; $display("FAIL R7 resume actual=%0d expected<=6", lat);
      end
      step(6);
      write_mask(4'b0101);
    end

    // R9: new mask applies at next stop
    tag = "R9"; write_mask(4'b0010); stop_n = 1'b0; step(14);
    check("R9", {28'd0, t_o}, {28'd0, 4'b0010 | {N{t_o[0]}}});
    // R8: disable overrides parking
    tag = "R8"; dis = 4'b0010; step(2);
    check("R8", {30'd0, t_o[1], c_o[1]}, {32'd0});
    dis = '0; stop_n = 1'b1; step(10);

    // R2 R6: short request pulses of varying width
    tag = "R2";
    for (int w = 1; w < 8; w++) begin
      write_mask(4'b1011); stop_n = 1'b0; step(w); stop_n = 1'b1; step(12);
    end
    tag = "R6";
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'h0) stop_n = ~stop_n;
      if (lfsr[9:5] == 5'h0) dis = lfsr[15:12];
      cfg_we = (lfsr[22:18] == 5'h1);
      cfg_mask = lfsr[27:24];
      step(1);
    end
    cfg_we = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule